// File: doc/BRIEF.md
# Packed SIMD Arithmetic Right Shifter

This block shifts every lane of a packed operand right arithmetically by one shared count. Each lane is 16 or 32 bits wide. The operand is either 64 or 128 bits. In every lane the vacated high bits take a copy of that lane's original sign bit. A count that reaches or passes the lane width does not wrap. It fills each lane entirely with its sign.

The count comes from one of two places, chosen by a select input. One source is the whole unsigned value of a 64-bit register. The other is an 8-bit immediate, which is zero-extended. The block sits in an execution pipeline as a two-stage unit. It takes one operation per cycle, and the result appears two clock edges after the operation is accepted. It produces no status flags.

Top module: `simd_sar_pipe`

## Requirements
- R1: With `lane_dw`=0, each 16-bit lane (bits 16k+15..16k) is shifted right by the same count, independently of its neighbours.
- R2: With `lane_dw`=1, each 32-bit lane (bits 32k+31..32k) is shifted right by the same count, independently of its neighbours.
- R3: Vacated high-order bits of a lane are copies of that lane's original top bit, and the top bit of every result lane equals the top bit of the input lane.
- R4: With 16-bit lanes, any count of 16 or more makes every lane 0x0000 or 0xFFFF, according to its sign. A count of 15 gives the same fill.
- R5: With 32-bit lanes, any count of 32 or more makes every lane 0x00000000 or 0xFFFFFFFF, according to its sign.
- R6: With `wide`=0, only `in_data[63:0]` is processed (4 word lanes or 2 doubleword lanes) and `out_data[127:64]` is zero. With `wide`=1, all 128 bits are processed.
- R7: With `cnt_sel`=0, the count is the full unsigned 64-bit `cnt_reg` (0x1_0000_0001 saturates) and `cnt_imm` is ignored. With `cnt_sel`=1, the count is `cnt_imm` zero-extended (0xFF saturates) and `cnt_reg` is ignored.
- R8: An operation accepted on a rising edge with `in_valid`=1 is presented with `out_valid`=1 right after the second following rising edge. Operations may be issued every cycle, and `out_valid` is 0 whenever no operation is due.
- R9: A count of zero returns the operand unchanged (in 64-bit mode, its low half with the upper half zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_data | input | 128 | Packed operand |
| cnt_reg | input | 64 | Register-sourced shift count |
| cnt_imm | input | 8 | Immediate shift count |
| cnt_sel | input | 1 | Count source: 0 register, 1 immediate |
| lane_dw | input | 1 | Lane size: 0 is 16-bit, 1 is 32-bit |
| wide | input | 1 | Operand width: 0 is 64-bit, 1 is 128-bit |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | Packed result |

## Verification
Two functions can meet in one cycle. A new operation can be captured into the first stage while the previous one leaves the second stage, and the two can use different lane sizes, widths and count sources. The bench provokes this by streaming back-to-back operations that switch mode on every cycle, saturating counts included. It checks each result in its own cycle against a bit-level model, so any mixing of control between stages shows up as a wrong lane value or a misplaced strobe.

// File: rtl/simd_sar_pkg.sv
package simd_sar_pkg;

  // Largest shift the datapath ever needs: one full doubleword lane.
  localparam int unsigned MAX_SHIFT = 32;
  localparam int unsigned AMT_W     = $clog2(MAX_SHIFT) + 1;

  typedef enum logic {
    LANE_HALF = 1'b0,
    LANE_FULL = 1'b1
  } lane_size_e;

  typedef struct packed {
    lane_size_e           lsize;
    logic                 wide;
    logic [AMT_W-1:0]     amt;
  } sar_ctl_t;

endpackage

// File: rtl/sar_count_sat.sv
module sar_count_sat
  import simd_sar_pkg::*;
#(
  parameter int unsigned REG_W = 64,
  parameter int unsigned IMM_W = 8
) (
  input  logic [REG_W-1:0] cnt_reg,
  input  logic [IMM_W-1:0] cnt_imm,
  input  logic             cnt_sel,
  output logic [AMT_W-1:0] amt
);

  logic [REG_W-1:0] cnt_full;

  always_comb begin
    cnt_full = cnt_sel ? REG_W'(cnt_imm) : cnt_reg;
    if (cnt_full >= REG_W'(MAX_SHIFT)) begin
      amt = AMT_W'(MAX_SHIFT);
    end else begin
      amt = cnt_full[AMT_W-1:0];
    end
  end

endmodule

// File: rtl/sar_lane.sv
module sar_lane
  import simd_sar_pkg::*;
#(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  output logic [LANE_W-1:0] dout
);

  localparam int unsigned SH_W = $clog2(LANE_W);

  logic [SH_W-1:0] eff;

  always_comb begin
    // A shift of LANE_W-1 already leaves nothing but sign copies.
    if (amt > AMT_W'(LANE_W - 1)) begin
      eff = SH_W'(LANE_W - 1);
    end else begin
      eff = amt[SH_W-1:0];
    end
    dout = LANE_W'($signed(din) >>> eff);
  end

endmodule

// File: rtl/simd_sar_pipe.sv
module simd_sar_pipe
  import simd_sar_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned REG_W  = 64,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [REG_W-1:0]  cnt_reg,
  input  logic [IMM_W-1:0]  cnt_imm,
  input  logic              cnt_sel,
  input  logic              lane_dw,
  input  logic              wide,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned N_HW   = DATA_W / 16;
  localparam int unsigned N_FW   = DATA_W / 32;

  // Stage 1: count resolution and width masking
  logic [AMT_W-1:0]  amt_d;
  sar_ctl_t          s1_ctl_d, s1_ctl_q;
  logic [DATA_W-1:0] s1_data_d, s1_data_q;
  logic              s1_valid_q;

  sar_count_sat #(.REG_W(REG_W), .IMM_W(IMM_W)) i_cnt (
    .cnt_reg (cnt_reg),
    .cnt_imm (cnt_imm),
    .cnt_sel (cnt_sel),
    .amt     (amt_d)
  );

  always_comb begin
    s1_ctl_d.lsize = lane_dw ? LANE_FULL : LANE_HALF;
    s1_ctl_d.wide  = wide;
    s1_ctl_d.amt   = amt_d;
    if (wide) begin
      s1_data_d = in_data;
    end else begin
      s1_data_d = {{(DATA_W-HALF_W){1'b0}}, in_data[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ctl_q   <= '0;
      s1_data_q  <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (in_valid) begin
        s1_ctl_q  <= s1_ctl_d;
        s1_data_q <= s1_data_d;
      end
    end
  end

  // Stage 2: lane shifters, both lane sizes in parallel
  logic [DATA_W-1:0] res_hw, res_fw, res_d;

  for (genvar g = 0; g < N_HW; g++) begin : g_hw
    sar_lane #(.LANE_W(16)) i_lane (
      .din  (s1_data_q[16*g +: 16]),
      .amt  (s1_ctl_q.amt),
      .dout (res_hw[16*g +: 16])
    );
  end

  for (genvar g = 0; g < N_FW; g++) begin : g_fw
    sar_lane #(.LANE_W(32)) i_lane (
      .din  (s1_data_q[32*g +: 32]),
      .amt  (s1_ctl_q.amt),
      .dout (res_fw[32*g +: 32])
    );
  end

  always_comb begin
    res_d = (s1_ctl_q.lsize == LANE_FULL) ? res_fw : res_hw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid_q;
      if (s1_valid_q) begin
        out_data <= res_d;
      end
    end
  end

endmodule

// File: rtl/simd_sar_chk.sv
module simd_sar_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned REG_W  = 64,
  parameter int unsigned IMM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [REG_W-1:0]  cnt_reg,
  input logic [IMM_W-1:0]  cnt_imm,
  input logic              cnt_sel,
  input logic              lane_dw,
  input logic              wide,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [REG_W-1:0]  c_cnt;
  logic              c_sat, c_zero;
  logic [DATA_W-1:0] c_in;
  logic [DATA_W-1:0] d1, d2;
  logic              dw1, dw2, w1, w2, sat1, sat2, z1, z2;

  always_comb begin
    c_cnt  = cnt_sel ? REG_W'(cnt_imm) : cnt_reg;
    c_sat  = lane_dw ? (c_cnt > REG_W'(31)) : (c_cnt > REG_W'(15));
    c_zero = (c_cnt == '0);
    c_in   = wide ? in_data : {{(DATA_W-HALF_W){1'b0}}, in_data[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0; d2 <= '0;
      dw1 <= 1'b0; dw2 <= 1'b0; w1 <= 1'b0; w2 <= 1'b0;
      sat1 <= 1'b0; sat2 <= 1'b0; z1 <= 1'b0; z2 <= 1'b0;
    end else begin
      d1 <= c_in;   d2 <= d1;
      dw1 <= lane_dw; dw2 <= dw1;
      w1 <= wide;   w2 <= w1;
      sat1 <= c_sat; sat2 <= sat1;
      z1 <= c_zero; z2 <= z1;
    end
  end

  logic msb_ok, hw_fill_ok, fw_fill_ok;

  always_comb begin
    msb_ok     = 1'b1;
    hw_fill_ok = 1'b1;
    fw_fill_ok = 1'b1;
    for (int k = 0; k < DATA_W / 16; k++) begin
      if (!dw2 && (out_data[16*k+15] != d2[16*k+15])) msb_ok = 1'b0;
      if (out_data[16*k +: 16] != '0 && out_data[16*k +: 16] != '1) hw_fill_ok = 1'b0;
    end
    for (int k = 0; k < DATA_W / 32; k++) begin
      if (dw2 && (out_data[32*k+31] != d2[32*k+31])) msb_ok = 1'b0;
      if (out_data[32*k +: 32] != '0 && out_data[32*k +: 32] != '1) fw_fill_ok = 1'b0;
    end
  end

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  p_sign_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> msb_ok);

  p_hw_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat2 && !dw2) |-> hw_fill_ok);

  p_fw_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat2 && dw2) |-> fw_fill_ok);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !w2) |-> (out_data[DATA_W-1:HALF_W] == '0));

  p_zero_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && z2) |-> (out_data == d2));

endmodule

bind simd_sar_pipe simd_sar_chk #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W),
  .IMM_W  (IMM_W)
) i_simd_sar_chk (.*);

// File: tb/test_simd_sar_pipe.sv
module test_simd_sar_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int MAXOPS = 8;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic [63:0]  cnt_reg;
  logic [7:0]   cnt_imm;
  logic         cnt_sel;
  logic         lane_dw;
  logic         wide;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  simd_sar_pipe i_simd_sar_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cnt_reg(cnt_reg), .cnt_imm(cnt_imm), .cnt_sel(cnt_sel),
    .lane_dw(lane_dw), .wide(wide), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [127:0] op_d   [MAXOPS];
  logic [63:0]  op_r   [MAXOPS];
  logic [7:0]   op_i   [MAXOPS];
  logic         op_sel [MAXOPS];
  logic         op_dw  [MAXOPS];
  logic         op_w   [MAXOPS];

  // Bit-level model written from the requirements.
  function automatic logic [127:0] model(input logic [127:0] d, input logic [63:0] creg,
                                         input logic [7:0] imm, input logic sel,
                                         input logic dw, input logic w);
    logic [127:0] r;
    logic [63:0]  cnt;
    int lw, nl, base;
    logic sgn;
    r   = '0;
    cnt = sel ? {56'd0, imm} : creg;
    lw  = dw ? 32 : 16;
    nl  = (w ? 128 : 64) / lw;
    for (int l = 0; l < nl; l++) begin
      base = l * lw;
      sgn  = d[base + lw - 1];
      for (int b = 0; b < lw; b++) begin
        if (cnt >= 64'(lw - b)) r[base + b] = sgn;
        else                    r[base + b] = d[base + b + int'(cnt)];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_op(input int k, input logic [127:0] d, input logic [63:0] creg,
                        input logic [7:0] imm, input logic sel, input logic dw, input logic w);
    op_d[k] = d; op_r[k] = creg; op_i[k] = imm;
    op_sel[k] = sel; op_dw[k] = dw; op_w[k] = w;
  endtask

  // Issue n operations back to back, checking each result two edges later.
  task automatic run_batch(input int n, input string req);
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if (c >= 2 && c - 2 < n) begin
        check({req, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        check(req, out_data, model(op_d[c-2], op_r[c-2], op_i[c-2],
                                   op_sel[c-2], op_dw[c-2], op_w[c-2]));
      end
      if (c == n + 2) check({req, " R8 idle"}, {127'd0, out_valid}, 128'd0);
      if (c < n) begin
        in_valid = 1'b1; in_data = op_d[c]; cnt_reg = op_r[c]; cnt_imm = op_i[c];
        cnt_sel = op_sel[c]; lane_dw = op_dw[c]; wide = op_w[c];
      end else begin
        in_valid = 1'b0; in_data = '0; cnt_reg = '0; cnt_imm = '0;
      end
    end
  endtask

  localparam logic [127:0] PAT_A = 128'h8001_7FFF_F0F0_0F0F_C000_1234_8000_0001;
  localparam logic [127:0] PAT_B = 128'hFEDC_BA98_7654_3210_8000_0000_7FFF_FFFF;

  task automatic t_reset;
    check("R8 reset out_valid", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_word_basic;
    set_op(0, PAT_A, 64'd4, 8'd0, 1'b0, 1'b0, 1'b1);
    set_op(1, PAT_B, 64'd1, 8'd0, 1'b0, 1'b0, 1'b1);
    run_batch(2, "R1 R3 word shift");
  endtask

  task automatic t_dword_basic;
    set_op(0, PAT_A, 64'd0, 8'd7, 1'b1, 1'b1, 1'b1);
    set_op(1, PAT_B, 64'd0, 8'd17, 1'b1, 1'b1, 1'b1);
    run_batch(2, "R2 R3 dword shift");
  endtask

  task automatic t_word_sat;
    set_op(0, PAT_A, 64'd15, 8'd0, 1'b0, 1'b0, 1'b1);
    set_op(1, PAT_A, 64'd16, 8'd0, 1'b0, 1'b0, 1'b1);
    set_op(2, PAT_B, 64'd200, 8'd0, 1'b0, 1'b0, 1'b1);
    run_batch(3, "R4 word saturate");
  endtask

  task automatic t_dword_sat;
    set_op(0, PAT_B, 64'd31, 8'd0, 1'b0, 1'b1, 1'b1);
    set_op(1, PAT_B, 64'd32, 8'd0, 1'b0, 1'b1, 1'b1);
    set_op(2, PAT_A, 64'd0, 8'd33, 1'b1, 1'b1, 1'b1);
    run_batch(3, "R5 dword saturate");
  endtask

  task automatic t_narrow;
    set_op(0, PAT_A, 64'd3, 8'd0, 1'b0, 1'b0, 1'b0);
    set_op(1, PAT_B, 64'd5, 8'd0, 1'b0, 1'b1, 1'b0);
    run_batch(2, "R6 64-bit mode");
  endtask

  task automatic t_count_src;
    set_op(0, PAT_A, 64'h1_0000_0001, 8'd1, 1'b0, 1'b0, 1'b1);
    set_op(1, PAT_B, 64'd2, 8'hFF, 1'b1, 1'b1, 1'b1);
    set_op(2, PAT_A, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 1'b1, 1'b0, 1'b1);
    set_op(3, PAT_B, 64'd2, 8'hFF, 1'b0, 1'b0, 1'b1);
    run_batch(4, "R7 count source");
  endtask

  task automatic t_zero;
    set_op(0, PAT_A, 64'd0, 8'd9, 1'b0, 1'b0, 1'b1);
    set_op(1, PAT_B, 64'd9, 8'd0, 1'b1, 1'b1, 1'b0);
    run_batch(2, "R9 zero count");
  endtask

  task automatic t_stream;
    set_op(0, PAT_B, 64'd3,  8'd0,  1'b0, 1'b0, 1'b1);
    set_op(1, PAT_A, 64'd0,  8'd40, 1'b1, 1'b1, 1'b0);
    set_op(2, PAT_B, 64'd20, 8'd0,  1'b0, 1'b0, 1'b0);
    set_op(3, PAT_A, 64'd0,  8'd12, 1'b1, 1'b1, 1'b1);
    set_op(4, PAT_B, 64'd0,  8'd0,  1'b1, 1'b0, 1'b1);
    set_op(5, PAT_A, 64'd31, 8'd0,  1'b0, 1'b1, 1'b0);
    run_batch(6, "R8 stream mixed modes");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cnt_reg = '0; cnt_imm = '0;
    cnt_sel = 1'b0; lane_dw = 1'b0; wide = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_word_basic;
    t_dword_basic;
    t_word_sat;
    t_dword_sat;
    t_narrow;
    t_count_src;
    t_zero;
    t_stream;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule